// File: doc/BRIEF.md
# Clock Divider Chain with Direct Bypass

This block holds the three digital counters that sit around an analog clock synthesizer. The reference divider brings the crystal clock down to the comparison frequency. The feedback divider divides the oscillator clock for the phase detector. The output divider produces the final clock from the oscillator. The phase detector, loop filter and oscillator lie outside the block. The block sees them only as its two input clocks.

Each divider is built from the same core: a restart-controlled phase counter and a registered output. The ratio is loaded only when the counter restarts. A new setting therefore never shortens or stretches the period that is already running. The output divider gives only even ratios from 2 to 30, so its duty is exactly half. Its all-zero code routes the oscillator clock straight to the output. This direct mode is meant for fast output clocks, where it keeps the counters' toggle rate low.

Top module: `clkDivChain`

## Requirements
- R1: While `rstN` is low, all counters are cleared asynchronously and `refDivOut`, `fbDivOut` and `clkOut` are low. This holds even when `outSel` selects the direct path.
- R2: A reference code n from 2 to 63 gives `refDivOut` a period of n `refClk` cycles. The output is high for floor(n/2) cycles and low for the rest, and it rises when the counter restarts.
- R3: Reference code 0 divides by 64 (32 high, 32 low). Reference code 1 divides by 2.
- R4: A feedback code n from 2 to 1023 gives `fbDivOut` a period of n `vcoClk` cycles, high for floor(n/2) of them. Code 0 divides by 1024 and code 1 divides by 2.
- R5: An output code k from 1 to 15 gives `clkOut` a period of 2k `vcoClk` cycles, high for k and low for k.
- R6: Output code 0 makes `clkOut` follow `vcoClk`, high while it is high and low while it is low. On leaving this mode, the divided clock resumes from the start of a period.
- R7: A change to any setting leaves the period in progress at its old ratio and takes effect at the next counter restart. The direct path is also entered only at such a period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference (crystal) clock |
| vcoClk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refSel | input | 6 | Reference divider code |
| fbSel | input | 10 | Feedback divider code |
| outSel | input | 4 | Output divider code; 0 selects the direct path |
| refDivOut | output | 1 | Divided reference clock |
| fbDivOut | output | 1 | Divided feedback clock |
| clkOut | output | 1 | Final output clock |

## Verification
The assertions assume that both input clocks keep running and that each setting is steady around the rising edge of the clock that samples it. The settings are quasi-static configuration and are not synchronized inside the block. The stimulus therefore changes a code only one nanosecond after a falling edge of the clock of its own domain, never near a rising edge. Reset is released at a time that meets no edge of either clock. The stimulus also waits for every expected period to be seen before it issues the next change.

// File: rtl/clkDivChainPkg.sv
package clkDivChainPkg;

  // Strobes issued by a divider's control half to its datapath half.
  typedef struct packed {
    logic restart;  // counter returns to zero on this edge
    logic drive;    // value the output flop takes on this edge
  } phaseCmd_t;

endpackage

// File: rtl/divPhaseCtl.sv
module divPhaseCtl
  import clkDivChainPkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] ratioNext,
  input  logic [CW-1:0] cnt,
  output phaseCmd_t     cmd
);

  logic          armed;
  logic [CW-1:0] ratioQ;
  logic          wrap;
  logic [CW-1:0] effRatio;
  logic [CW-1:0] nextPos;

  // The ratio in force is only replaced at a restart, so a period in progress
  // always finishes at the ratio it began with.
  always_comb begin
    wrap        = !armed || (cnt == ratioQ - CW'(1));
    effRatio    = wrap ? ratioNext : ratioQ;
    nextPos     = wrap ? '0 : cnt + CW'(1);
    cmd.restart = wrap;
    cmd.drive   = nextPos < (effRatio >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      ratioQ <= '0;
    end else if (wrap) begin
      armed  <= 1'b1;
      ratioQ <= ratioNext;
    end
  end

endmodule

// File: rtl/divPhaseDp.sv
module divPhaseDp
  import clkDivChainPkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  phaseCmd_t     cmd,
  output logic [CW-1:0] cnt,
  output logic          divOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else begin
      cnt    <= cmd.restart ? '0 : cnt + CW'(1);
      divOut <= cmd.drive;
    end
  end

endmodule

// File: rtl/clkBypassSel.sv
module clkBypassSel (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic bypassReq,
  input  logic divIn,
  output logic bypassOn,
  output logic clkOut
);

  // The mode flop changes only on a restart edge. Entering the direct path
  // happens after a low phase, and leaving it starts a high phase, so both
  // switches line up with a rising edge of the oscillator clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bypassOn <= 1'b0;
    end else if (restart) begin
      bypassOn <= bypassReq;
    end
  end

  assign clkOut = bypassOn ? clk : divIn;

endmodule

// File: rtl/clkDivChain.sv
module clkDivChain
  import clkDivChainPkg::*;
#(
  parameter int REF_W = 6,
  parameter int FB_W  = 10,
  parameter int OUT_W = 4
) (
  input  logic             refClk,
  input  logic             vcoClk,
  input  logic             rstN,
  input  logic [REF_W-1:0] refSel,
  input  logic [FB_W-1:0]  fbSel,
  input  logic [OUT_W-1:0] outSel,
  output logic             refDivOut,
  output logic             fbDivOut,
  output logic             clkOut
);

  localparam int REF_CW = REF_W + 1;
  localparam int FB_CW  = FB_W + 1;
  localparam int OUT_CW = OUT_W + 1;

  logic [REF_CW-1:0] refRatio;
  logic [FB_CW-1:0]  fbRatio;
  logic [OUT_CW-1:0] outRatio;
  logic              outBypassReq;

  phaseCmd_t         refCmd;
  phaseCmd_t         fbCmd;
  phaseCmd_t         outCmd;
  logic [REF_CW-1:0] refCnt;
  logic [FB_CW-1:0]  fbCnt;
  logic [OUT_CW-1:0] outCnt;
  logic              outDiv;
  logic              bypassOn;

  // Code decode: zero selects the full range, one is raised to the minimum
  // ratio of two; output codes double, with zero picking the direct path.
  always_comb begin
    if (refSel == '0)                refRatio = REF_CW'(2 ** REF_W);
    else if (refSel == REF_W'(1))    refRatio = REF_CW'(2);
    else                             refRatio = REF_CW'(refSel);

    if (fbSel == '0)                 fbRatio = FB_CW'(2 ** FB_W);
    else if (fbSel == FB_W'(1))      fbRatio = FB_CW'(2);
    else                             fbRatio = FB_CW'(fbSel);

    outBypassReq = (outSel == '0);
    outRatio     = outBypassReq ? OUT_CW'(1) : {outSel, 1'b0};
  end

  divPhaseCtl #(.CW(REF_CW)) u_refCtl (
    .clk(refClk), .rstN(rstN), .ratioNext(refRatio), .cnt(refCnt), .cmd(refCmd)
  );
  divPhaseDp #(.CW(REF_CW)) u_refDp (
    .clk(refClk), .rstN(rstN), .cmd(refCmd), .cnt(refCnt), .divOut(refDivOut)
  );

  divPhaseCtl #(.CW(FB_CW)) u_fbCtl (
    .clk(vcoClk), .rstN(rstN), .ratioNext(fbRatio), .cnt(fbCnt), .cmd(fbCmd)
  );
  divPhaseDp #(.CW(FB_CW)) u_fbDp (
    .clk(vcoClk), .rstN(rstN), .cmd(fbCmd), .cnt(fbCnt), .divOut(fbDivOut)
  );

  divPhaseCtl #(.CW(OUT_CW)) u_outCtl (
    .clk(vcoClk), .rstN(rstN), .ratioNext(outRatio), .cnt(outCnt), .cmd(outCmd)
  );
  divPhaseDp #(.CW(OUT_CW)) u_outDp (
    .clk(vcoClk), .rstN(rstN), .cmd(outCmd), .cnt(outCnt), .divOut(outDiv)
  );

  clkBypassSel u_bypass (
    .clk(vcoClk), .rstN(rstN), .restart(outCmd.restart), .bypassReq(outBypassReq),
    .divIn(outDiv), .bypassOn(bypassOn), .clkOut(clkOut)
  );

endmodule

// File: rtl/clkDivChainChk.sv
module clkDivChainChk
  import clkDivChainPkg::*;
#(
  parameter int REF_CW = 7,
  parameter int FB_CW  = 11,
  parameter int OUT_CW = 5
) (
  input logic              refClk,
  input logic              vcoClk,
  input logic              rstN,
  input phaseCmd_t         refCmd,
  input logic [REF_CW-1:0] refCnt,
  input logic [FB_CW-1:0]  fbCnt,
  input logic [OUT_CW-1:0] outCnt,
  input logic              refDivOut,
  input logic              fbDivOut,
  input logic              outDiv,
  input logic              bypassOn,
  input logic              clkOut
);

  // R1: outputs quiet while reset is held
  always @(negedge refClk) begin
    if (!rstN) begin
      a_r1_ref_quiet: assert (!refDivOut);
    end
  end

  always @(negedge vcoClk) begin
    if (!rstN) begin
      a_r1_vco_quiet: assert (!fbDivOut && !bypassOn && !clkOut);
    end
  end

  // R7: a restart strobe from control returns the datapath counter to zero
  a_r7_restart_clears: assert property (@(posedge refClk) disable iff (!rstN)
    refCmd.restart |=> (refCnt == '0));

  // R2: without a restart the counter advances by exactly one
  a_r2_count_steps: assert property (@(posedge refClk) disable iff (!rstN)
    !refCmd.restart |=> (refCnt == $past(refCnt) + REF_CW'(1)));

  // R2: the reference output rises only at the start of a period
  a_r2_ref_rise_start: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(refDivOut) |-> (refCnt == '0));

  // R4: the feedback output rises only at the start of a period
  a_r4_fb_rise_start: assert property (@(posedge vcoClk) disable iff (!rstN)
    $rose(fbDivOut) |-> (fbCnt == '0));

  // R5: the output divider rises only at the start of a period
  a_r5_out_rise_start: assert property (@(posedge vcoClk) disable iff (!rstN)
    $rose(outDiv) |-> (outCnt == '0));

  // R6: in the direct path the divided flop stays low
  a_r6_bypass_div_low: assert property (@(posedge vcoClk) disable iff (!rstN)
    bypassOn |-> !outDiv);

endmodule

bind clkDivChain clkDivChainChk #(
  .REF_CW(REF_CW), .FB_CW(FB_CW), .OUT_CW(OUT_CW)
) u_chk (
  .refClk(refClk), .vcoClk(vcoClk), .rstN(rstN), .refCmd(refCmd),
  .refCnt(refCnt), .fbCnt(fbCnt), .outCnt(outCnt), .refDivOut(refDivOut),
  .fbDivOut(fbDivOut), .outDiv(outDiv), .bypassOn(bypassOn), .clkOut(clkOut)
);

// File: tb/clkDivChain_test.sv
module clkDivChain_test;

  logic       refClk = 1'b0;
  logic       vcoClk = 1'b0;
  logic       rstN   = 1'b0;
  logic [5:0] refSel = 6'd5;
  logic [9:0] fbSel  = 10'd3;
  logic [3:0] outSel = 4'd0;
  logic       refDivOut;
  logic       fbDivOut;
  logic       clkOut;

  int nRun  = 0;
  int nFail = 0;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } expItem_t;

  expItem_t expQ[3][$];
  bit       skipMon[3];
  int       curCode[3];

  always #4  vcoClk = ~vcoClk;   // 125 MHz oscillator stand-in
  always #20 refClk = ~refClk;   // 25 MHz reference stand-in

  clkDivChain uut (
    .refClk(refClk), .vcoClk(vcoClk), .rstN(rstN), .refSel(refSel),
    .fbSel(fbSel), .outSel(outSel), .refDivOut(refDivOut),
    .fbDivOut(fbDivOut), .clkOut(clkOut)
  );

  task automatic checkVal(string tag, string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ratioOf(int ch, int code);
    case (ch)
      0:       return (code == 0) ? 64 : ((code == 1) ? 2 : code);
      1:       return (code == 0) ? 1024 : ((code == 1) ? 2 : code);
      default: return 2 * code;
    endcase
  endfunction

  function automatic logic sigOf(int ch);
    case (ch)
      0:       return refDivOut;
      1:       return fbDivOut;
      default: return clkOut;
    endcase
  endfunction

  task automatic chanEdge(int ch);
    if (ch == 0) @(negedge refClk);
    else         @(negedge vcoClk);
  endtask

  task automatic applySel(int ch, int code);
    case (ch)
      0:       refSel = 6'(code);
      1:       fbSel  = 10'(code);
      default: outSel = 4'(code);
    endcase
    curCode[ch] = code;
  endtask

  task automatic pushExp(int ch, int code, int n, string tag);
    expItem_t it;
    it.hi  = ratioOf(ch, code) / 2;
    it.lo  = ratioOf(ch, code) - it.hi;
    it.tag = tag;
    for (int i = 0; i < n; i++) expQ[ch].push_back(it);
  endtask

  // Monitor: measures high and low runs between rising edges, sampled at
  // falling edges, and compares every complete period with the queue head.
  task automatic monitorChan(int ch);
    int       hi = 0;
    int       lo = 0;
    bit       tracking = 1'b0;
    logic     prev = 1'b0;
    logic     v;
    expItem_t it;
    forever begin
      chanEdge(ch);
      v = sigOf(ch);
      if (skipMon[ch] || !rstN) begin
        skipMon[ch] = 1'b0;
        tracking    = 1'b0;
        prev        = rstN ? v : 1'b0;
      end else begin
        if (v && !prev) begin
          if (tracking && expQ[ch].size() > 0) begin
            it = expQ[ch].pop_front();
            checkVal(it.tag, $sformatf("ch%0d high run", ch), hi, it.hi);
            checkVal(it.tag, $sformatf("ch%0d low run", ch), lo, it.lo);
          end
          tracking = 1'b1;
          hi = 1;
          lo = 0;
        end else if (tracking) begin
          if (v) hi++;
          else   lo++;
        end
        prev = v;
      end
    end
  endtask

  task automatic waitDrained(int ch);
    while (expQ[ch].size() != 0) chanEdge(ch);
  endtask

  task automatic waitHighSample(int ch);
    do begin
      chanEdge(ch);
      #1;
    end while (!sigOf(ch));
  endtask

  // Driver: change a code mid-period; the running period (R7) keeps the old
  // ratio, the following ones use the new one.
  task automatic changeSel(int ch, int code, int nNew, string tag);
    waitDrained(ch);
    waitHighSample(ch);
    pushExp(ch, curCode[ch], 1, "R7");
    applySel(ch, code);
    pushExp(ch, code, nNew, tag);
  endtask

  initial begin
    curCode[0] = 5;
    curCode[1] = 3;
    curCode[2] = 0;
    fork
      monitorChan(0);
      monitorChan(1);
      monitorChan(2);
    join_none

    // R1: reset holds outputs low, even with the direct path selected
    repeat (4) begin
      @(posedge vcoClk);
      #2;
      checkVal("R1", "clkOut in reset", int'(clkOut), 0);
      checkVal("R1", "fbDivOut in reset", int'(fbDivOut), 0);
    end
    @(negedge refClk);
    #2;
    checkVal("R1", "refDivOut in reset", int'(refDivOut), 0);
    applySel(2, 2);
    #61 rstN = 1'b1;
    repeat (10) @(posedge refClk);

    changeSel(0, 7, 3, "R2");
    changeSel(0, 0, 2, "R3");
    changeSel(0, 1, 3, "R3");
    changeSel(0, 12, 2, "R2");

    changeSel(1, 10, 3, "R4");
    changeSel(1, 0, 2, "R4");
    changeSel(1, 1, 3, "R4");
    changeSel(1, 1023, 2, "R4");

    changeSel(2, 15, 3, "R5");
    changeSel(2, 1, 3, "R5");
    changeSel(2, 4, 2, "R5");

    // R6 / R7: enter the direct path mid-period
    waitDrained(2);
    waitHighSample(2);
    applySel(2, 0);
    repeat (40) @(posedge vcoClk);
    for (int i = 0; i < 6; i++) begin
      @(posedge vcoClk);
      #2;
      checkVal("R6", "clkOut while oscillator high", int'(clkOut), 1);
      @(negedge vcoClk);
      #2;
      checkVal("R6", "clkOut while oscillator low", int'(clkOut), 0);
    end
    // R6: leave the direct path
    @(negedge vcoClk);
    #1;
    skipMon[2] = 1'b1;
    applySel(2, 3);
    pushExp(2, 3, 3, "R6");

    waitDrained(0);
    waitDrained(1);
    waitDrained(2);

    // R1: asynchronous reset mid-run
    @(posedge vcoClk);
    #1 rstN = 1'b0;
    #1;
    checkVal("R1", "refDivOut after async reset", int'(refDivOut), 0);
    checkVal("R1", "fbDivOut after async reset", int'(fbDivOut), 0);
    checkVal("R1", "clkOut after async reset", int'(clkOut), 0);
    repeat (3) @(posedge refClk);
    #2;
    checkVal("R1", "clkOut held in reset", int'(clkOut), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule